// File: doc/BRIEF.md
# Programmable Address Region Decoder

This block keeps a bank of 32-bit region descriptors and sorts every access the core issues into a target and a chip select. Each descriptor names a target kind in its top three bits. The target is external-bus I/O, external-bus memory, the boot device, one of two ROM devices, SDRAM, or nothing. The rest of the descriptor gives a start address and a size. For I/O the unit is one byte. For memory the unit is 4kB or 64kB, picked by a page-size bit, and the size and start fields change width with that bit.

An access has a valid strobe, an address-space bit (memory or I/O), an operation code (read, write or fetch) and an address. The result comes out of a register one cycle later. It gives a hit flag, the target code, the external chip-select index and a cacheable flag. It also gives a protection-violation flag, which blocks the chip-select qualifier. When descriptors overlap, the one with the lowest number wins. Software loads descriptors one at a time through a write port, and a write is seen by the first access presented in a later cycle.

Top module: `addr_region_decoder`

## Requirements
- R1: After reset every descriptor is zero, so every region is disabled and no lookup hits. No result is flagged valid until an access is presented.
- R2: Descriptor bits [31:29] select the target: 3'b001 external I/O, 3'b010 external memory, 3'b100 boot, 3'b101 ROM one, 3'b110 ROM two, 3'b111 SDRAM. The codes 3'b000 and 3'b011 disable the region. On a hit, res_target carries this code; on a miss every result field other than res_valid is zero.
- R3: An I/O descriptor matches I/O addresses from its start in bits [15:0] up to start + n, where n is bits [24:16]. That is n+1 bytes.
- R4: A memory descriptor with page bit [25] = 0 starts at bits [17:0] × 4096 and covers (bits [24:18] + 1) × 4096 bytes.
- R5: A memory descriptor with page bit [25] = 1 starts at bits [13:0] × 65536 and covers (bits [24:14] + 1) × 65536 bytes. Example: 0xE3FFC000 is SDRAM over 0 to 128MB-1.
- R6: An access with acc_io = 1 matches only I/O descriptors. An access with acc_io = 0 matches only memory-kind descriptors.
- R7: When several descriptors match, the one with the lowest index decides the result.
- R8: For external targets, res_cs_idx is bits [28:26] and the access is not cacheable. For boot, ROM and SDRAM targets, res_cs_idx is 0 and the access is cacheable exactly when bit 27 is 0.
- R9: A write (acc_op = 2'b01) that hits a boot, ROM or SDRAM region with bit 26 set raises res_viol and drops res_cs_valid, while res_hit stays 1.
- R10: A fetch (acc_op = 2'b10) in memory space that hits a boot, ROM or SDRAM region with bit 28 set raises res_viol and drops res_cs_valid. Reads (2'b00 and the spare code 2'b11) never violate.
- R11: An access presented with acc_valid on one rising edge gives res_valid and its result after that edge, for one cycle. With acc_valid low, res_valid is low.
- R12: A descriptor write takes effect for accesses presented in later cycles. An access in the same cycle sees the old value. A write whose index is not below NUM_REGIONS changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IDX_W | Descriptor number to write |
| cfg_wdata | input | 32 | Descriptor value |
| acc_valid | input | 1 | Access present this cycle |
| acc_io | input | 1 | 1 = I/O space, 0 = memory space |
| acc_op | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_addr | input | ADDR_W | Access address |
| res_valid | output | 1 | Result of last cycle's access |
| res_hit | output | 1 | Some region matched |
| res_target | output | 3 | Target code of the winning region |
| res_cs_idx | output | 3 | External chip-select index |
| res_cs_valid | output | 1 | Chip select may be driven (hit, no violation) |
| res_cacheable | output | 1 | Access may be cached |
| res_viol | output | 1 | Protection violation |

## Verification
The bench builds the decoder with NUM_REGIONS = 6, which gives a 3-bit index. Indices 6 and 7 can then be written, and the bench checks that those writes are dropped. ADDR_W stays at 32. This lets accesses sit exactly at and just past the 4kB, 64kB and 128MB region limits, and at addresses above every memory region. Six descriptors are enough for overlapping regions, for disabling the winner, and for checking that a lower index beats a later, smaller region.

// File: rtl/ard_pkg.sv
package ard_pkg;

    localparam int REG_W      = 32;
    localparam int TGT_LSB    = 29;
    localparam int CSF_LSB    = 26;
    localparam int PG_BIT     = 25;
    localparam int NX_BIT     = 28;
    localparam int NC_BIT     = 27;
    localparam int WP_BIT     = 26;
    localparam int SHIFT_4K   = 12;
    localparam int SHIFT_64K  = 16;

    typedef enum logic [2:0] {
        TGT_OFF   = 3'd0,
        TGT_XIO   = 3'd1,
        TGT_XMEM  = 3'd2,
        TGT_RSVD  = 3'd3,
        TGT_BOOT  = 3'd4,
        TGT_ROM1  = 3'd5,
        TGT_ROM2  = 3'd6,
        TGT_SDRAM = 3'd7
    } tgt_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FETCH = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef struct packed {
        logic       match;
        logic [2:0] tgt;
        logic [2:0] cs;
        logic       cacheable;
        logic       no_write;
        logic       no_exec;
    } rgn_hit_t;

    typedef struct packed {
        logic       valid;
        logic       hit;
        logic [2:0] tgt;
        logic [2:0] cs;
        logic       cs_valid;
        logic       cacheable;
        logic       viol;
    } res_t;

endpackage

// File: rtl/ard_reg_bank.sv
module ard_reg_bank
    import ard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [REG_W-1:0]                  wdata_i,
    output logic [NUM_REGIONS-1:0][REG_W-1:0] regs_o
);

    logic [NUM_REGIONS-1:0][REG_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (we_i && (32'(idx_i) == i)) begin
                regs_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/ard_region_match.sv
module ard_region_match
    import ard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [REG_W-1:0]  rgn_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_i,
    output rgn_hit_t          hit_o
);

    localparam int CMP_W = ((ADDR_W > 32) ? ADDR_W : 32) + 1;

    tgt_e             tgt;
    logic             is_io, is_mem, is_ext;
    logic [CMP_W-1:0] base, span, limit, addr_x;

    always_comb begin
        tgt    = tgt_e'(rgn_i[REG_W-1:TGT_LSB]);
        is_io  = (tgt == TGT_XIO);
        is_ext = (tgt == TGT_XIO) || (tgt == TGT_XMEM);
        is_mem = (tgt == TGT_XMEM) || (tgt == TGT_BOOT) || (tgt == TGT_ROM1)
              || (tgt == TGT_ROM2) || (tgt == TGT_SDRAM);
        addr_x = CMP_W'(addr_i);

        if (is_io) begin
            base = CMP_W'(rgn_i[15:0]);
            span = CMP_W'(rgn_i[24:16]) + CMP_W'(1);
        end else if (!rgn_i[PG_BIT]) begin
            base = CMP_W'(rgn_i[17:0]) << SHIFT_4K;
            span = (CMP_W'(rgn_i[24:18]) + CMP_W'(1)) << SHIFT_4K;
        end else begin
            base = CMP_W'(rgn_i[13:0]) << SHIFT_64K;
            span = (CMP_W'(rgn_i[24:14]) + CMP_W'(1)) << SHIFT_64K;
        end
        limit = base + span;

        hit_o.match     = (addr_x >= base) && (addr_x < limit)
                       && (io_i ? is_io : is_mem);
        hit_o.tgt       = tgt;
        hit_o.cs        = is_ext ? rgn_i[TGT_LSB-1:CSF_LSB] : 3'd0;
        hit_o.cacheable = !is_ext && !rgn_i[NC_BIT];
        hit_o.no_write  = !is_ext && rgn_i[WP_BIT];
        hit_o.no_exec   = !is_ext && rgn_i[NX_BIT];
    end

endmodule

// File: rtl/ard_priority.sv
module ard_priority
    import ard_pkg::*;
#(
    parameter int NUM_REGIONS = 16
) (
    input  rgn_hit_t [NUM_REGIONS-1:0] hits_i,
    output logic                       found_o,
    output rgn_hit_t                   win_o
);

    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hits_i[i].match) begin
                found_o = 1'b1;
                win_o   = hits_i[i];
            end
        end
    end

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import ard_pkg::*;
#(
    parameter  int NUM_REGIONS = 16,
    parameter  int ADDR_W      = 32,
    localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_io,
    input  logic [1:0]        acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [2:0]        res_target,
    output logic [2:0]        res_cs_idx,
    output logic              res_cs_valid,
    output logic              res_cacheable,
    output logic              res_viol
);

    logic [NUM_REGIONS-1:0][REG_W-1:0] regs;
    rgn_hit_t [NUM_REGIONS-1:0]        hits;
    rgn_hit_t                          win;
    logic                              found;
    res_t                              res_d, res_q;
    op_e                               op;

    ard_reg_bank #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .idx_i   (cfg_idx),
        .wdata_i (cfg_wdata),
        .regs_o  (regs)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        ard_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .rgn_i  (regs[g]),
            .addr_i (acc_addr),
            .io_i   (acc_io),
            .hit_o  (hits[g])
        );
    end

    ard_priority #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_prio (
        .hits_i  (hits),
        .found_o (found),
        .win_o   (win)
    );

    always_comb begin
        op          = op_e'(acc_op);
        res_d       = '0;
        res_d.valid = acc_valid;
        if (acc_valid && found) begin
            res_d.hit       = 1'b1;
            res_d.tgt       = win.tgt;
            res_d.cs        = win.cs;
            res_d.cacheable = win.cacheable;
            res_d.viol      = ((op == OP_WRITE) && win.no_write)
                           || (!acc_io && (op == OP_FETCH) && win.no_exec);
            res_d.cs_valid  = !res_d.viol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid     = res_q.valid;
    assign res_hit       = res_q.hit;
    assign res_target    = res_q.tgt;
    assign res_cs_idx    = res_q.cs;
    assign res_cs_valid  = res_q.cs_valid;
    assign res_cacheable = res_q.cacheable;
    assign res_viol      = res_q.viol;

endmodule

// File: rtl/ard_checker.sv
module ard_checker (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       res_valid,
    input logic       res_hit,
    input logic [2:0] res_target,
    input logic [2:0] res_cs_idx,
    input logic       res_cs_valid,
    input logic       res_cacheable,
    input logic       res_viol
);

    assert_result_follows_R11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_target == 3'd0 && res_cs_idx == 3'd0
                      && !res_cs_valid && !res_cacheable && !res_viol));

    assert_hit_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    assert_viol_blocks_cs_R9: assert property (@(posedge clk) disable iff (rst)
        res_viol |-> (res_hit && !res_cs_valid));

    assert_hit_drives_cs_R10: assert property (@(posedge clk) disable iff (rst)
        (res_hit && !res_viol) |-> res_cs_valid);

    assert_ext_uncached_R8: assert property (@(posedge clk) disable iff (rst)
        (res_hit && (res_target == 3'd1 || res_target == 3'd2)) |-> !res_cacheable);

    assert_internal_cs_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (res_hit && res_target[2]) |-> (res_cs_idx == 3'd0));

endmodule

bind addr_region_decoder ard_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_target    (res_target),
    .res_cs_idx    (res_cs_idx),
    .res_cs_valid  (res_cs_valid),
    .res_cacheable (res_cacheable),
    .res_viol      (res_viol)
);

// File: tb/sim_addr_region_decoder.sv
module sim_addr_region_decoder;

    localparam int NR   = 6;
    localparam int IW   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_io = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic [31:0] acc_addr = '0;
    logic        res_valid, res_hit, res_cs_valid, res_cacheable, res_viol;
    logic [2:0]  res_target, res_cs_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] shadow [NR];

    typedef struct {
        logic [9:0] exp;
        string      req;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    addr_region_decoder #(.NUM_REGIONS(NR), .ADDR_W(32)) u0 (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_wdata,
        .acc_valid, .acc_io, .acc_op, .acc_addr,
        .res_valid, .res_hit, .res_target, .res_cs_idx,
        .res_cs_valid, .res_cacheable, .res_viol
    );

    function automatic logic [31:0] mk_io(input logic [2:0] cs, input logic [8:0] n,
                                          input logic [15:0] s);
        return {3'b001, cs, 1'b0, n, s};
    endfunction

    function automatic logic [31:0] mk_m4k(input logic [2:0] t, input logic [2:0] f,
                                           input logic [6:0] n, input logic [17:0] s);
        return {t, f, 1'b0, n, s};
    endfunction

    function automatic logic [31:0] mk_m64k(input logic [2:0] t, input logic [2:0] f,
                                            input logic [10:0] n, input logic [13:0] s);
        return {t, f, 1'b1, n, s};
    endfunction

    // packed {hit, target[2:0], cs[2:0], cs_valid, cacheable, viol}
    function automatic logic [9:0] model(input logic io, input logic [1:0] op,
                                         input logic [31:0] a);
        for (int i = 0; i < NR; i++) begin
            logic [31:0] r;
            logic [2:0]  t;
            longint      lo, len;
            bit          ext, wp, nx, vio, memk;
            r    = shadow[i];
            t    = r[31:29];
            memk = (t == 3'd2) || t[2];
            if (t == 3'd1) begin
                lo  = longint'(r[15:0]);
                len = longint'(r[24:16]) + 1;
            end else if (memk && r[25]) begin
                lo  = longint'(r[13:0]) * 65536;
                len = (longint'(r[24:14]) + 1) * 65536;
            end else if (memk) begin
                lo  = longint'(r[17:0]) * 4096;
                len = (longint'(r[24:18]) + 1) * 4096;
            end else begin
                continue;
            end
            if (io != (t == 3'd1)) continue;
            if (longint'(a) < lo || longint'(a) >= lo + len) continue;
            ext = (t == 3'd1) || (t == 3'd2);
            wp  = !ext && r[26];
            nx  = !ext && r[28];
            vio = (op == 2'd1 && wp) || (!io && op == 2'd2 && nx);
            return {1'b1, t, (ext ? r[28:26] : 3'd0), !vio, (!ext && !r[27]), vio};
        end
        return 10'd0;
    endfunction

    task automatic access(input logic io, input logic [1:0] op, input logic [31:0] a,
                          input string req);
        item_t it;
        @(negedge clk);
        cfg_we    = 1'b0;
        acc_valid = 1'b1;
        acc_io    = io;
        acc_op    = op;
        acc_addr  = a;
        it.exp    = model(io, op, a);
        it.req    = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            cfg_we    = 1'b0;
        end
    endtask

    task automatic write_reg(input logic [IW-1:0] idx, input logic [31:0] v);
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = v;
        if (int'(idx) < NR) shadow[idx] = v;
    endtask

    // write and access in the same cycle: the access sees the old descriptor
    task automatic write_and_access(input logic [IW-1:0] idx, input logic [31:0] v,
                                    input logic io, input logic [1:0] op,
                                    input logic [31:0] a, input string req);
        item_t it;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = v;
        acc_valid = 1'b1;
        acc_io    = io;
        acc_op    = op;
        acc_addr  = a;
        it.exp    = model(io, op, a);
        it.req    = req;
        q.push_back(it);
        if (int'(idx) < NR) shadow[idx] = v;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            logic [9:0] act;
            act = {res_hit, res_target, res_cs_idx, res_cs_valid, res_cacheable, res_viol};
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected result actual=%b expected=none", act);
            end else begin
                item_t it;
                it = q.pop_front();
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_quiet(input string req);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
            errors++;
            $display("FAIL %s actual=%b%b expected=00", req, res_valid, res_hit);
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset res_valid actual=%b expected=0", res_valid);
        end
        rst = 1'b0;
        check_quiet("R1");
        // R1: all descriptors disabled after reset
        access(1'b0, 2'd0, 32'h0000_0000, "R1 mem miss after reset");
        access(1'b1, 2'd0, 32'h0000_02f8, "R1 io miss after reset");
        idle(2);
        check_quiet("R11 idle");

        // R5: 128MB SDRAM at 0, 64kB pages
        write_reg(3'd0, 32'hE3FF_C000);
        access(1'b0, 2'd0, 32'h0000_0000, "R5 sdram base");
        access(1'b0, 2'd1, 32'h07FF_FFFC, "R5 sdram top write");
        access(1'b0, 2'd2, 32'h0800_0000, "R5 sdram past end");
        access(1'b0, 2'd0, 32'hFFFF_FFFF, "R5 high miss");

        // R3: external I/O, cs 3, 8 bytes at 0x2f8
        write_reg(3'd1, mk_io(3'd3, 9'd7, 16'h02F8));
        access(1'b1, 2'd0, 32'h0000_02F8, "R3 io first byte");
        access(1'b1, 2'd1, 32'h0000_02FF, "R3 io last byte");
        access(1'b1, 2'd0, 32'h0000_0300, "R3 io past end");
        access(1'b1, 2'd0, 32'h0000_02F7, "R3 io below start");
        // R6: address spaces kept apart
        access(1'b0, 2'd0, 32'h0000_02F8, "R6 mem access ignores io region");
        access(1'b1, 2'd0, 32'h0000_0000, "R6 io access ignores sdram");

        // R4 / R8: external memory, 4kB pages, one page, cs 4
        write_reg(3'd2, mk_m4k(3'b010, 3'd4, 7'd0, 18'h18100));
        access(1'b0, 2'd1, 32'h1810_0000, "R4 xmem base write");
        access(1'b0, 2'd2, 32'h1810_0FFF, "R4 xmem last byte fetch");
        access(1'b0, 2'd0, 32'h1810_1000, "R4 xmem past end");
        access(1'b0, 2'd0, 32'h180F_FFFF, "R4 xmem below start");

        // R9 / R10 / R8: ROM one, 16MB at 0x10000000, all restrictions set
        write_reg(3'd3, mk_m64k(3'b101, 3'b111, 11'd255, 14'h1000));
        access(1'b0, 2'd2, 32'h1000_0000, "R10 fetch exec-disabled");
        access(1'b0, 2'd1, 32'h10FF_FFFF, "R9 write protected");
        access(1'b0, 2'd0, 32'h1080_0000, "R8 uncached read");
        access(1'b0, 2'd3, 32'h1080_0000, "R10 spare op read");
        access(1'b0, 2'd0, 32'h1100_0000, "R5 rom past end");

        // R7: overlapping ROM two at 0x10000000, 64kB
        write_reg(3'd4, mk_m64k(3'b110, 3'b000, 11'd0, 14'h1000));
        access(1'b0, 2'd1, 32'h1000_0010, "R7 lower index wins");
        write_reg(3'd3, 32'h0);
        access(1'b0, 2'd1, 32'h1000_0010, "R2 disabled winner falls through");
        write_reg(3'd3, {3'b011, 29'h02FF_D000});
        access(1'b0, 2'd0, 32'h1000_0010, "R2 reserved code disables");
        // boot at 0 overlaps SDRAM (index 0)
        write_reg(3'd5, mk_m64k(3'b100, 3'b001, 11'd7, 14'h0));
        access(1'b0, 2'd1, 32'h0000_1000, "R7 sdram index 0 beats boot");
        write_reg(3'd0, 32'h0);
        access(1'b0, 2'd1, 32'h0000_1000, "R9 boot write protected");
        access(1'b0, 2'd2, 32'h0007_FFFF, "R8 boot cacheable fetch");
        access(1'b0, 2'd0, 32'h0008_0000, "R5 boot past end");

        // R12: out-of-range index ignored, same-cycle write unseen
        write_reg(3'd6, mk_io(3'd1, 9'd15, 16'h0100));
        write_reg(3'd7, mk_io(3'd2, 9'd15, 16'h0100));
        access(1'b1, 2'd0, 32'h0000_0100, "R12 index beyond bank ignored");
        write_and_access(3'd1, mk_io(3'd5, 9'd3, 16'h0100),
                         1'b1, 2'd0, 32'h0000_0100, "R12 same-cycle old value");
        access(1'b1, 2'd0, 32'h0000_0103, "R12 new value next cycle");
        access(1'b1, 2'd2, 32'h0000_0104, "R3 io past new end");

        idle(3);
        check_quiet("R11 idle after burst");
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11 results missing actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule